// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire bus slave for a configuration register space of up to 128 bytes (18 by default). It answers a single 7-bit address and supports four access kinds: writing one byte, reading one byte, writing a run of bytes and reading a run of bytes. The top bit of the command byte chooses between single-byte and run access. For a single-byte access the low seven bits of the command give the register offset. A run access always starts at offset 0. A run write carries a byte count ahead of its data. A run read first sends back the size of the register space.

The register storage lives outside the block. The slave reads the current contents from a flat parallel bus and writes back through one-hot per-byte strobes that carry a shared data byte. A parallel protection mask marks bits as read-only. On every write those bits keep their present value, which is how strap latches and identification fields survive software writes. The bus pins are open-drain: the block samples SCL and SDA and asserts an enable that pulls SDA low. It never stretches the clock.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address 0x69 (first byte 0xD2 for a write, 0xD3 for a read). It leaves any other address unacknowledged and issues no write strobe until the next start.
- R2: Command bit 7 = 1 selects a single-byte write. The one data byte after the command goes to offset = command bits 6:0 and is acknowledged. A further data byte in the same transfer is not acknowledged and is not written.
- R3: A single-byte read (command with bit 7 = 1, repeated start, read address) returns the register at offset = command bits 6:0. It is sent most significant bit first.
- R4: Command bit 7 = 0 selects a run write. The byte after the command is a count N. The next N data bytes are written to offsets 0, 1, 2, … in order. Any byte beyond N is not acknowledged and not written.
- R5: A run write ended by a stop before N bytes have arrived keeps every byte that was fully received and acknowledged. Nothing else is written.
- R6: A run read (command 0x00, repeated start, read address) first returns the count 18. It then returns registers from offset 0 upward, and returns 0x00 for offsets past the last register, for as long as the master acknowledges.
- R7: On every write, bits set in the read-only mask of the target register keep that register's current value. Only the unmasked bits take the written data.
- R8: A stop returns the slave to idle. Clock pulses after a stop and without a new start are not acknowledged and cause no writes.
- R9: A write strobe is one-hot and lasts exactly one system clock. It is issued in the same cycle that the slave starts pulling SDA low to acknowledge that data byte.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: After reset the slave drives no SDA and issues no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sdaOe | output | 1 | When 1, pull the data line low |
| regRdBus | input | NUM_REGS*8 | Current register contents, offset i at bits 8i+7:8i |
| roMaskBus | input | NUM_REGS*8 | Read-only mask, same layout; 1 = bit ignores writes |
| wrStrobe | output | NUM_REGS | One-hot write strobe, bit i writes offset i |
| wrByte | output | 8 | Merged byte to store at the strobed offset |

## Verification
The register write and the acknowledge drive fall on the same clock edge. In that same cycle the written byte is merged with the protected bits of the target register. Both are provoked by single-byte and run writes to offsets whose mask has read-only bits. A reference register file in the bench stores whatever the strobes deliver. That file is judged against a shadow copy that the bench computes from the requirements, and it is also read back over the bus. The acknowledge bit for every byte is compared through the same scoreboard, so a strobe that comes without an acknowledge, or an acknowledge that comes without a strobe, shows up as a mismatch.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  // Bus events seen by the control, produced by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sdaLvl;
  } busEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic txCount;
    logic setOffset;
    logic clrOffset;
    logic writeReg;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_COUNT,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } slvState_t;

endpackage

// File: rtl/smb_cfg_datapath.sv
module smb_cfg_datapath
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 18,
  parameter int OFFSET_W = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  dpCtrl_t               ctl,
  input  logic [NUM_REGS*8-1:0] regRdBus,
  input  logic [NUM_REGS*8-1:0] roMaskBus,
  output busEvt_t               evt,
  output logic [7:0]            shiftByte,
  output logic                  txNextMsb,
  output logic [NUM_REGS-1:0]   wrStrobe,
  output logic [7:0]            wrByte
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [OFFSET_W-1:0] LAST_OFF = OFFSET_W'(NUM_REGS - 1);

  // two-flop synchronisers plus one history flop for edge detection
  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  always_comb begin
    evt.sclRise   = sclS & ~sclPrev;
    evt.sclFall   = ~sclS & sclPrev;
    evt.startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
    evt.stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
    evt.sdaLvl    = sdaS;
  end

  // register views padded to a power of two
  logic [7:0] regArr  [DEPTH];
  logic [7:0] maskArr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gView
    if (g < NUM_REGS) begin : gReal
      assign regArr[g]  = regRdBus[g*8 +: 8];
      assign maskArr[g] = roMaskBus[g*8 +: 8];
    end else begin : gPad
      assign regArr[g]  = 8'h00;
      assign maskArr[g] = 8'h00;
    end
  end

  logic [OFFSET_W-1:0] offset;
  logic [IDX_W-1:0]    offIdx;
  logic                offValid;
  logic [7:0]          curByte, curMask, txByteNext, shiftReg;

  assign offIdx   = offset[IDX_W-1:0];
  assign offValid = (offset <= LAST_OFF);
  assign curByte  = offValid ? regArr[offIdx]  : 8'h00;
  assign curMask  = offValid ? maskArr[offIdx] : 8'h00;

  assign txByteNext = ctl.txCount ? 8'(NUM_REGS) : curByte;
  assign txNextMsb  = txByteNext[7];
  assign shiftByte  = shiftReg;

  // shift register, offset pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= 8'h00;
      offset   <= '0;
    end else begin
      if (ctl.shiftIn)
        shiftReg <= {shiftReg[6:0], sdaS};
      else if (ctl.shiftOut)
        shiftReg <= {shiftReg[6:0], 1'b0};
      else if (ctl.loadTx)
        shiftReg <= txByteNext;

      if (ctl.setOffset)
        offset <= shiftReg[OFFSET_W-1:0];
      else if (ctl.clrOffset)
        offset <= '0;
      else if ((ctl.writeReg || (ctl.loadTx && !ctl.txCount)) && (offset != '1))
        offset <= offset + 1'b1;
    end
  end

  // registered write port with read-only merge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= '0;
      wrByte   <= 8'h00;
    end else if (ctl.writeReg && offValid) begin
      wrStrobe <= {{(NUM_REGS-1){1'b0}}, 1'b1} << offIdx;
      wrByte   <= (shiftReg & ~curMask) | (curByte & curMask);
    end else begin
      wrStrobe <= '0;
    end
  end

endmodule

// File: rtl/smb_cfg_ctrl.sv
module smb_cfg_ctrl
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic [7:0] shiftByte,
  input  logic       txNextMsb,
  output dpCtrl_t    ctl,
  output logic       sdaOe
);

  slvState_t state, nState;
  logic [3:0] bitCnt, nBitCnt;
  logic [7:0] remain, nRemain;
  logic inAck, nInAck;
  logic blockMode, nBlockMode;
  logic sendCount, nSendCount;
  logic readDir, nReadDir;
  logic masterNack, nMasterNack;
  logic oeR, nOe;

  assign sdaOe = oeR;

  always_comb begin
    nState      = state;
    nBitCnt     = bitCnt;
    nRemain     = remain;
    nInAck      = inAck;
    nBlockMode  = blockMode;
    nSendCount  = sendCount;
    nReadDir    = readDir;
    nMasterNack = masterNack;
    nOe         = oeR;
    ctl         = '0;

    if (evt.stopSeen) begin
      nState = ST_IDLE;
      nInAck = 1'b0;
      nOe    = 1'b0;
    end else if (evt.startSeen) begin
      nState  = ST_ADDR;
      nBitCnt = 4'd0;
      nInAck  = 1'b0;
      nOe     = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
          if (!inAck) begin
            if (evt.sclRise && (bitCnt < 4'd8)) begin
              ctl.shiftIn = 1'b1;
              nBitCnt     = bitCnt + 4'd1;
            end else if (evt.sclFall && (bitCnt == 4'd8)) begin
              nInAck = 1'b1;
              unique case (state)
                ST_ADDR: begin
                  if (shiftByte[7:1] == SLAVE_ADDR) begin
                    nOe      = 1'b1;
                    nReadDir = shiftByte[0];
                    if (shiftByte[0] && blockMode) begin
                      ctl.clrOffset = 1'b1;
                      nSendCount    = 1'b1;
                    end
                  end else begin
                    nState = ST_SKIP;
                    nInAck = 1'b0;
                  end
                end
                ST_CMD: begin
                  nOe        = 1'b1;
                  nBlockMode = ~shiftByte[7];
                  nRemain    = {7'd0, shiftByte[7]};
                  if (shiftByte[7]) ctl.setOffset = 1'b1;
                  else              ctl.clrOffset = 1'b1;
                end
                ST_COUNT: begin
                  nOe     = 1'b1;
                  nRemain = shiftByte;
                end
                default: begin
                  if (remain != 8'd0) begin
                    nOe          = 1'b1;
                    ctl.writeReg = 1'b1;
                    nRemain      = remain - 8'd1;
                  end else begin
                    nState = ST_SKIP;
                    nInAck = 1'b0;
                  end
                end
              endcase
            end
          end else if (evt.sclFall) begin
            nOe     = 1'b0;
            nInAck  = 1'b0;
            nBitCnt = 4'd0;
            unique case (state)
              ST_ADDR: begin
                if (readDir) begin
                  nState      = ST_RDATA;
                  ctl.loadTx  = 1'b1;
                  ctl.txCount = sendCount;
                  nSendCount  = 1'b0;
                  nOe         = ~txNextMsb;
                end else begin
                  nState = ST_CMD;
                end
              end
              ST_CMD:  nState = blockMode ? ST_COUNT : ST_WDATA;
              default: nState = ST_WDATA;
            endcase
          end
        end

        ST_RDATA: begin
          if (!inAck) begin
            if (evt.sclRise) begin
              nBitCnt = bitCnt + 4'd1;
            end else if (evt.sclFall) begin
              if (bitCnt < 4'd8) begin
                ctl.shiftOut = 1'b1;
                nOe          = ~shiftByte[6];
              end else begin
                nOe    = 1'b0;
                nInAck = 1'b1;
              end
            end
          end else begin
            if (evt.sclRise) begin
              nMasterNack = evt.sdaLvl;
            end else if (evt.sclFall) begin
              if (masterNack) begin
                nState = ST_SKIP;
                nInAck = 1'b0;
              end else begin
                ctl.loadTx  = 1'b1;
                ctl.txCount = sendCount;
                nSendCount  = 1'b0;
                nOe         = ~txNextMsb;
                nInAck      = 1'b0;
                nBitCnt     = 4'd0;
              end
            end
          end
        end

        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= 4'd0;
      remain     <= 8'd0;
      inAck      <= 1'b0;
      blockMode  <= 1'b0;
      sendCount  <= 1'b0;
      readDir    <= 1'b0;
      masterNack <= 1'b0;
      oeR        <= 1'b0;
    end else begin
      state      <= nState;
      bitCnt     <= nBitCnt;
      remain     <= nRemain;
      inAck      <= nInAck;
      blockMode  <= nBlockMode;
      sendCount  <= nSendCount;
      readDir    <= nReadDir;
      masterNack <= nMasterNack;
      oeR        <= nOe;
    end
  end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS   = 18,
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  input  logic [NUM_REGS*8-1:0] regRdBus,
  input  logic [NUM_REGS*8-1:0] roMaskBus,
  output logic [NUM_REGS-1:0]   wrStrobe,
  output logic [7:0]            wrByte
);

  busEvt_t    evt;
  dpCtrl_t    ctl;
  logic [7:0] shiftByte;
  logic       txNextMsb;

  smb_cfg_datapath #(
    .NUM_REGS(NUM_REGS),
    .OFFSET_W(7)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ctl       (ctl),
    .regRdBus  (regRdBus),
    .roMaskBus (roMaskBus),
    .evt       (evt),
    .shiftByte (shiftByte),
    .txNextMsb (txNextMsb),
    .wrStrobe  (wrStrobe),
    .wrByte    (wrByte)
  );

  smb_cfg_ctrl #(
    .SLAVE_ADDR(SLAVE_ADDR)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .shiftByte (shiftByte),
    .txNextMsb (txNextMsb),
    .ctl       (ctl),
    .sdaOe     (sdaOe)
  );

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
  parameter int NUM_REGS = 18
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_REGS-1:0]   wrStrobe,
  input logic [7:0]            wrByte,
  input logic [NUM_REGS*8-1:0] regRdBus,
  input logic [NUM_REGS*8-1:0] roMaskBus
);

  // R9: strobe is one-hot
  a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrobe));

  // R9: strobe lasts one cycle
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe != '0) |=> (wrStrobe == '0));

  // R9: a write always coincides with an acknowledge drive
  a_r9_strobe_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe != '0) |-> sdaOe);

  // R10: SDA drive changes only while SCL is low
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclIn);

  // R7: protected bits of the written byte equal the current contents
  for (genvar g = 0; g < NUM_REGS; g++) begin : gRo
    a_r7_readonly_kept: assert property (@(posedge clk) disable iff (!rstN)
      wrStrobe[g] |-> (((wrByte ^ regRdBus[g*8 +: 8]) & roMaskBus[g*8 +: 8]) == 8'h00));
  end

endmodule

bind smb_cfg_slave smb_cfg_checker #(.NUM_REGS(NUM_REGS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaOe     (sdaOe),
  .wrStrobe  (wrStrobe),
  .wrByte    (wrByte),
  .regRdBus  (regRdBus),
  .roMaskBus (roMaskBus)
);

// File: tb/smb_cfg_slave_test.sv
`timescale 1ns/1ps
module smb_cfg_slave_test;

  localparam int  NREG = 18;
  localparam time Q    = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaOe;
  logic [NREG*8-1:0] regRdBus, roMaskBus;
  logic [NREG-1:0]   wrStrobe;
  logic [7:0]        wrByte;

  logic [7:0] model  [NREG];
  logic [7:0] shadow [NREG];
  int strobeCnt = 0;
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  smb_cfg_slave #(.NUM_REGS(NREG), .SLAVE_ADDR(7'h69)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regRdBus(regRdBus), .roMaskBus(roMaskBus),
    .wrStrobe(wrStrobe), .wrByte(wrByte)
  );

  function automatic logic [7:0] initVal(int i);
    if (i == 1) return 8'h15;
    if (i == 6) return 8'h08;
    return 8'((i * 37) + 3);
  endfunction

  function automatic logic [7:0] maskOf(int i);
    if (i == 1) return 8'h1F;
    if (i == 6) return 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic [7:0] mrg(logic [7:0] cur, logic [7:0] nw, logic [7:0] m);
    return (nw & ~m) | (cur & m);
  endfunction

  // reference register file fed only by the strobes
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) model[i] <= initVal(i);
    end else begin
      for (int i = 0; i < NREG; i++) if (wrStrobe[i]) model[i] <= wrByte;
      if (wrStrobe != '0) strobeCnt <= strobeCnt + 1;
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regRdBus[i*8 +: 8]  = model[i];
      roMaskBus[i*8 +: 8] = maskOf(i);
    end
  end

  // scoreboard
  typedef struct {
    logic [7:0] val;
    string      tag;
  } item_t;
  item_t expQ[$];
  logic [7:0] obsVal;
  event obsEv;

  task automatic pushExp(logic [7:0] v, string tag);
    item_t it;
    it.val = v;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic observe(logic [7:0] v);
    obsVal = v;
    ->obsEv;
    #1;
  endtask

  initial begin
    forever begin
      @(obsEv);
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard: unexpected item actual=%02h expected=none", obsVal);
      end else begin
        item_t it;
        it = expQ.pop_front();
        if (obsVal !== it.val) begin
          mismatched++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, obsVal, it.val);
        end
      end
    end
  end

  task automatic checkNow(logic [31:0] act, logic [31:0] exp, string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bit-level master
  task automatic sendBit(logic b);
    #Q sdaM = b;
    #Q sclM = 1'b1;
    #(2*Q) sclM = 1'b0;
  endtask

  task automatic recvBit(output logic b);
    #Q sdaM = 1'b1;
    #Q sclM = 1'b1;
    #Q b = sdaLine;
    #Q sclM = 1'b0;
  endtask

  task automatic busStart();
    #Q sdaM = 1'b1;
    #Q sclM = 1'b1;
    #(2*Q) sdaM = 1'b0;
    #(2*Q) sclM = 1'b0;
  endtask

  task automatic busStop();
    #Q sdaM = 1'b0;
    #Q sclM = 1'b1;
    #(2*Q) sdaM = 1'b1;
    #(2*Q);
  endtask

  task automatic sendChk(logic [7:0] b, logic expAck, string tag);
    logic lvl;
    pushExp({7'd0, expAck}, tag);
    for (int k = 7; k >= 0; k--) sendBit(b[k]);
    recvBit(lvl);
    observe({7'd0, ~lvl});
  endtask

  task automatic recvChk(logic [7:0] expv, logic giveAck, string tag);
    logic [7:0] got;
    logic lvl;
    pushExp(expv, tag);
    for (int k = 7; k >= 0; k--) begin
      recvBit(lvl);
      got[k] = lvl;
    end
    sendBit(~giveAck);
    observe(got);
  endtask

  task automatic byteWrite(logic [6:0] off, logic [7:0] d);
    busStart();
    sendChk(8'hD2, 1'b1, "R1 address ack");
    sendChk({1'b1, off}, 1'b1, "R2 command ack");
    sendChk(d, 1'b1, "R2 data ack");
    busStop();
    shadow[off] = mrg(shadow[off], d, maskOf(int'(off)));
  endtask

  task automatic byteRead(logic [6:0] off, string tag);
    busStart();
    sendChk(8'hD2, 1'b1, "R1 address ack");
    sendChk({1'b1, off}, 1'b1, "R3 command ack");
    busStart();
    sendChk(8'hD3, 1'b1, "R3 read address ack");
    recvChk(shadow[off], 1'b0, tag);
    busStop();
  endtask

  task automatic checkRegs(string tag);
    for (int i = 0; i < NREG; i++) checkNow(32'(model[i]), 32'(shadow[i]), tag);
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int sc;
    for (int i = 0; i < NREG; i++) shadow[i] = initVal(i);
    #41 rstN = 1'b1;
    #20;

    // R11: reset state
    checkNow(32'(sdaOe), 0, "R11 sdaOe after reset");
    checkNow(32'(wrStrobe), 0, "R11 wrStrobe after reset");

    // R1: foreign address ignored
    sc = strobeCnt;
    busStart();
    sendChk(8'h54, 1'b0, "R1 foreign write address nack");
    sendChk(8'h83, 1'b0, "R1 byte after foreign address nack");
    busStop();
    busStart();
    sendChk(8'hA5, 1'b0, "R1 foreign read address nack");
    busStop();
    checkNow(32'(strobeCnt), 32'(sc), "R1 no strobe for foreign address");

    // R2/R3: single-byte write and read back
    byteWrite(7'd3, 8'hA5);
    checkRegs("R2 byte write offset 3");
    byteRead(7'd3, "R3 byte read offset 3");

    // R2: extra data byte in a single-byte write is refused
    sc = strobeCnt;
    busStart();
    sendChk(8'hD2, 1'b1, "R1 address ack");
    sendChk(8'h84, 1'b1, "R2 command ack");
    sendChk(8'h5A, 1'b1, "R2 data ack");
    sendChk(8'hC3, 1'b0, "R2 second data byte nack");
    busStop();
    shadow[4] = 8'h5A;
    checkNow(32'(strobeCnt - sc), 1, "R2 only one strobe");
    checkRegs("R2 extra byte not written");

    // R7: read-only bits kept
    byteWrite(7'd6, 8'hF3);
    checkNow(32'(model[6]), 32'hF8, "R7 vendor nibble kept");
    byteWrite(7'd1, 8'hFF);
    checkNow(32'(model[1]), 32'hF5, "R7 strap bits kept");
    byteRead(7'd6, "R7 read back offset 6");

    // R4: run write with count 4 and one surplus byte
    begin
      logic [7:0] d [5];
      d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33; d[3] = 8'h44; d[4] = 8'h55;
      busStart();
      sendChk(8'hD2, 1'b1, "R1 address ack");
      sendChk(8'h00, 1'b1, "R4 command ack");
      sendChk(8'd4, 1'b1, "R4 count ack");
      for (int i = 0; i < 4; i++) begin
        sendChk(d[i], 1'b1, "R4 data ack");
        shadow[i] = mrg(shadow[i], d[i], maskOf(i));
      end
      sendChk(d[4], 1'b0, "R4 byte beyond count nack");
      busStop();
      checkRegs("R4 run write contents");
    end

    // R5: run write stopped early
    busStart();
    sendChk(8'hD2, 1'b1, "R1 address ack");
    sendChk(8'h00, 1'b1, "R5 command ack");
    sendChk(8'd5, 1'b1, "R5 count ack");
    sendChk(8'hC0, 1'b1, "R5 data ack");
    shadow[0] = 8'hC0;
    sendChk(8'h66, 1'b1, "R5 data ack");
    shadow[1] = mrg(shadow[1], 8'h66, maskOf(1));
    busStop();
    checkRegs("R5 early stop contents");

    // R6: run read with count, all registers, and two bytes past the end
    busStart();
    sendChk(8'hD2, 1'b1, "R1 address ack");
    sendChk(8'h00, 1'b1, "R6 command ack");
    busStart();
    sendChk(8'hD3, 1'b1, "R6 read address ack");
    recvChk(8'd18, 1'b1, "R6 count byte");
    for (int i = 0; i < NREG; i++) recvChk(shadow[i], 1'b1, "R6 run read data");
    recvChk(8'h00, 1'b1, "R6 past end zero");
    recvChk(8'h00, 1'b0, "R6 past end zero last");
    busStop();

    // R8: clocking after a stop with no new start
    sc = strobeCnt;
    busStart();
    sendChk(8'hD2, 1'b1, "R1 address ack");
    sendChk(8'h82, 1'b1, "R8 command ack");
    busStop();
    sclM = 1'b0;
    sendChk(8'hD2, 1'b0, "R8 no ack without start");
    sendChk(8'h77, 1'b0, "R8 no ack without start");
    busStop();
    checkNow(32'(strobeCnt), 32'(sc), "R8 no strobe after stop");
    checkRegs("R8 contents unchanged");
    byteRead(7'd2, "R8 slave usable after new start");

    #(4*Q);
    checkNow(32'(expQ.size()), 0, "scoreboard drained");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule